// File: doc/BRIEF.md
# Regulator Undervoltage Fault Supervisor

This block supervises the power-good signal of the supply regulator that feeds a companion microcontroller. It filters short dips out of the power-good input. Once the regulator has been on long enough to settle, a lasting loss of power-good sets a sticky error flag. Unless software has disabled that reaction, the same event moves the chip into a fault mode. In fault mode every amplifier and driver enable is held off and the over-temperature monitor is forced on. The regulator itself stays on so the system can try to recover.

The block owns the enable register of the other analog blocks. It saves that register on entry to fault mode and puts it back on exit. Fault mode ends in one of two ways: a periodic recheck finds power-good high, or software reads the status register while power-good is high. An over-temperature event during fault mode moves the block into a deeper state that also turns the regulator off. When the temperature input clears, the block returns to the regulator fault mode.

All time bases are counts of the input clock, set by parameters. The defaults match an 8 MHz clock: a 125 µs glitch filter, a 10 ms settling window and a one-second recheck.

Top module: `reg_uv_supervisor`

## Requirements
- R1: `pg_ok` rises one cycle after `pg_raw` is sampled high. It falls only after `pg_raw` has been sampled low on DEGLITCH_CYC consecutive cycles. A shorter low pulse leaves `pg_ok` high.
- R2: `err_flag` is set when `pg_ok` is low, `ldo_en` is high, and `ldo_en` has been high for at least BLANK_CYC cycles since it last rose or since the last `vsel_stb`. It is never set before that.
- R3: A `vsel_stb` pulse restarts the settling window, so the error can only be set BLANK_CYC cycles after the strobe.
- R4: The cycle the error condition sets `err_flag` with `err_dis` low, `fault_active` goes high. With `err_dis` high, `err_flag` is set but `fault_active` stays low.
- R5: While `fault_active` is high, `blk_en` is all zero and `otmon_force` is high. In the regulator fault state (no over-temperature), `ldo_en_o` equals `ldo_en`.
- R6: In normal mode, a `blk_wr` pulse loads `blk_wdata` into `blk_en` one cycle later. During fault mode, `blk_wr` is ignored.
- R7: In the regulator fault state, `pg_ok` is checked every RECHECK_CYC cycles, counted from entry. If it is high, the block returns to normal mode with `blk_en` restored to its value before entry.
- R8: A `stat_rd` pulse in the regulator fault state while `pg_ok` is high exits fault mode and restores `blk_en`. While `pg_ok` is low, a `stat_rd` pulse does not exit.
- R9: `err_flag` stays high after a fault exit and clears only on `stat_rd`. If `stat_rd` and a new error condition fall in the same cycle, `err_flag` stays high.
- R10: `ot_flag` high in the regulator fault state moves the block to the over-temperature state. There `ldo_en_o` is low, `fault_active` stays high and `blk_en` stays zero. When `ot_flag` drops, the block returns to the regulator fault state with `ldo_en_o` following `ldo_en` again.
- R11: After reset, all outputs are low: normal mode, error clear, enables and the saved enable vector zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_raw | input | 1 | Undeglitched power-good from the regulator comparator |
| ldo_en | input | 1 | Software enable of the regulator |
| vsel_stb | input | 1 | One-cycle pulse when the regulator output voltage is changed |
| err_dis | input | 1 | Stops the error from entering fault mode |
| ot_flag | input | 1 | Over-temperature indication |
| stat_rd | input | 1 | One-cycle pulse when software reads the status register |
| blk_wr | input | 1 | Write strobe for the block enable register |
| blk_wdata | input | EN_W | Write data for the block enable register |
| pg_ok | output | 1 | Deglitched power-good status |
| err_flag | output | 1 | Sticky regulator error flag |
| fault_active | output | 1 | High in either fault state |
| otmon_force | output | 1 | Forces the over-temperature monitor on |
| ldo_en_o | output | 1 | Regulator enable after the fault override |
| blk_en | output | EN_W | Effective amplifier and driver enables |

## Verification
The bench builds the block with DEGLITCH_CYC=4, BLANK_CYC=20, RECHECK_CYC=50 and EN_W=4. These values bring the glitch filter edge, the settling window with its restart and the periodic recheck within a few dozen cycles, so each can be checked at its exact boundary cycle. The 4-bit enable vector is wide enough to show that a write made during fault mode is dropped and that the saved pattern comes back after both exit paths and after a nested over-temperature episode.

// File: rtl/reg_uv_pkg.sv
package reg_uv_pkg;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_UVF  = 2'd1,
    ST_OTF  = 2'd2
  } sup_state_e;

  // Width of a counter that must hold values 0..n.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Sticky flag update: a set request outranks a clear request.
  function automatic logic sticky_next(input logic set_req, input logic clr_req,
                                       input logic cur);
    return set_req | (cur & ~clr_req);
  endfunction

endpackage

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
  parameter int DEGLITCH_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_raw,
  output logic pg_status
);
  import reg_uv_pkg::*;

  localparam int CW = cnt_w(DEGLITCH_CYC);

  logic [CW-1:0] lo_cnt;
  logic          lo_full;

  assign lo_full = (lo_cnt == CW'(DEGLITCH_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt    <= '0;
      pg_status <= 1'b0;
    end else if (pg_raw) begin
      lo_cnt    <= '0;
      pg_status <= 1'b1;
    end else if (lo_full) begin
      pg_status <= 1'b0;
    end else begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R1: status only falls after a low sample and only rises after a high one
  assert_pg_fall_needs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_status) |-> $past(!pg_raw));
  assert_pg_rise_needs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_status) |-> $past(pg_raw));

endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int BLANK_CYC = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ldo_en,
  input  logic vsel_stb,
  output logic blank_done
);
  import reg_uv_pkg::*;

  localparam int BW = cnt_w(BLANK_CYC);

  logic [BW-1:0] bcnt;
  logic          restart;

  // Holding the count at zero while disabled makes every enable rise a restart.
  assign restart    = !ldo_en || vsel_stb;
  assign blank_done = (bcnt == BW'(BLANK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bcnt <= '0;
    else if (restart)     bcnt <= '0;
    else if (!blank_done) bcnt <= bcnt + 1'b1;
  end

  // R3: a voltage change reopens the settling window
  assert_blank_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vsel_stb) |-> !blank_done);

endmodule

// File: rtl/fault_fsm.sv
module fault_fsm #(
  parameter int RECHECK_CYC = 8000000,
  parameter int EN_W        = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    uv_cond,
  input  logic                    pg_status,
  input  logic                    err_dis,
  input  logic                    ot_flag,
  input  logic                    stat_rd,
  input  logic                    blk_wr,
  input  logic [EN_W-1:0]         blk_wdata,
  output reg_uv_pkg::sup_state_e  state,
  output logic                    recheck_tick,
  output logic [EN_W-1:0]         blk_en
);
  import reg_uv_pkg::*;

  localparam int RW = cnt_w(RECHECK_CYC);

  logic [RW-1:0]   rc;
  logic [EN_W-1:0] saved_en;
  logic            enter_req;
  logic            exit_req;
  sup_state_e      state_nx;

  assign recheck_tick = (state == ST_UVF) && (rc == RW'(RECHECK_CYC - 1));
  assign enter_req    = (state == ST_NORM) && uv_cond && !err_dis;
  assign exit_req     = (state == ST_UVF) && !ot_flag && pg_status &&
                        (recheck_tick || stat_rd);

  always_comb begin
    state_nx = state;
    case (state)
      ST_NORM: if (enter_req) state_nx = ST_UVF;
      ST_UVF: begin
        if (ot_flag)       state_nx = ST_OTF;
        else if (exit_req) state_nx = ST_NORM;
      end
      ST_OTF:  if (!ot_flag) state_nx = ST_UVF;
      default: state_nx = ST_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_NORM;
      rc       <= '0;
      saved_en <= '0;
      blk_en   <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != ST_UVF || state != ST_UVF || recheck_tick) rc <= '0;
      else                                                      rc <= rc + 1'b1;
      if (enter_req) begin
        saved_en <= blk_en;
        blk_en   <= '0;
      end else if (exit_req) begin
        blk_en <= saved_en;
      end else if (state == ST_NORM && blk_wr) begin
        blk_en <= blk_wdata;
      end
    end
  end

  // R5: enables stay masked in either fault state
  assert_fault_masks_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_NORM) |-> (blk_en == '0));
  // R7: leaving the regulator fault needs power-good high
  assert_exit_needs_pg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_UVF && state == ST_NORM) |-> $past(pg_status));
  // R10: the over-temperature state always hands back to the regulator fault
  assert_ot_returns_uvf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_OTF && state != ST_OTF) |-> (state == ST_UVF));

endmodule

// File: rtl/reg_uv_supervisor.sv
module reg_uv_supervisor #(
  parameter int DEGLITCH_CYC = 1000,
  parameter int BLANK_CYC    = 80000,
  parameter int RECHECK_CYC  = 8000000,
  parameter int EN_W         = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_raw,
  input  logic            ldo_en,
  input  logic            vsel_stb,
  input  logic            err_dis,
  input  logic            ot_flag,
  input  logic            stat_rd,
  input  logic            blk_wr,
  input  logic [EN_W-1:0] blk_wdata,
  output logic            pg_ok,
  output logic            err_flag,
  output logic            fault_active,
  output logic            otmon_force,
  output logic            ldo_en_o,
  output logic [EN_W-1:0] blk_en
);
  import reg_uv_pkg::*;

  logic       pg_status;
  logic       blank_done;
  logic       uv_cond;
  logic       recheck_tick;
  sup_state_e fsm_state;

  pg_deglitch #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_dgl (
    .clk(clk), .rst_n(rst_n), .pg_raw(pg_raw), .pg_status(pg_status)
  );

  blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .ldo_en(ldo_en), .vsel_stb(vsel_stb),
    .blank_done(blank_done)
  );

  assign uv_cond = !pg_status && ldo_en && blank_done;

  fault_fsm #(.RECHECK_CYC(RECHECK_CYC), .EN_W(EN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .uv_cond(uv_cond), .pg_status(pg_status),
    .err_dis(err_dis), .ot_flag(ot_flag), .stat_rd(stat_rd),
    .blk_wr(blk_wr), .blk_wdata(blk_wdata), .state(fsm_state),
    .recheck_tick(recheck_tick), .blk_en(blk_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else        err_flag <= sticky_next(uv_cond, stat_rd, err_flag);
  end

  assign pg_ok        = pg_status;
  assign fault_active = (fsm_state != ST_NORM);
  assign otmon_force  = fault_active;
  assign ldo_en_o     = ldo_en && (fsm_state != ST_OTF);

  // R2: the error only rises on a qualified undervoltage
  assert_err_rise_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(uv_cond));
  // R9: the error only clears on a status read
  assert_err_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(stat_rd));
  // R4: fault entry is blocked by the disable bit
  assert_entry_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_active) |-> ($past(!err_dis) && err_flag));
  // R10: regulator is off whenever the over-temperature state holds it
  assert_ldo_off_in_ot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fsm_state) == ST_UVF && $past(ot_flag) && ldo_en) |-> !ldo_en_o);

endmodule

// File: tb/tb_reg_uv_supervisor.sv
module tb_reg_uv_supervisor;

  localparam int DG = 4;
  localparam int BL = 20;
  localparam int RC = 50;
  localparam int W  = 4;

  localparam logic [8:0] M_PG  = 9'h100;
  localparam logic [8:0] M_ERR = 9'h080;
  localparam logic [8:0] M_FLT = 9'h040;
  localparam logic [8:0] M_OTM = 9'h020;
  localparam logic [8:0] M_LDO = 9'h010;
  localparam logic [8:0] M_EN  = 9'h00F;
  localparam logic [8:0] M_ALL = 9'h1FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_raw = 1'b0, ldo_en = 1'b0, vsel_stb = 1'b0, err_dis = 1'b0;
  logic ot_flag = 1'b0, stat_rd = 1'b0, blk_wr = 1'b0;
  logic [W-1:0] blk_wdata = '0;
  logic pg_ok, err_flag, fault_active, otmon_force, ldo_en_o;
  logic [W-1:0] blk_en;

  always #2.5 clk = ~clk;

  reg_uv_supervisor #(.DEGLITCH_CYC(DG), .BLANK_CYC(BL), .RECHECK_CYC(RC), .EN_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .pg_raw(pg_raw), .ldo_en(ldo_en), .vsel_stb(vsel_stb),
    .err_dis(err_dis), .ot_flag(ot_flag), .stat_rd(stat_rd), .blk_wr(blk_wr),
    .blk_wdata(blk_wdata), .pg_ok(pg_ok), .err_flag(err_flag),
    .fault_active(fault_active), .otmon_force(otmon_force), .ldo_en_o(ldo_en_o),
    .blk_en(blk_en)
  );

  typedef struct {
    int         due;
    logic [8:0] mask;
    logic [8:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares due expectations a little after each rising edge.
  always @(posedge clk) begin
    exp_t e;
    logic [8:0] obs;
    #2;
    obs = {pg_ok, err_flag, fault_active, otmon_force, ldo_en_o, blk_en};
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.due < cyc) begin
        failures++;
        $display("FAIL %s: expectation for cycle %0d missed", e.tag, e.due);
      end else if ((obs & e.mask) != (e.val & e.mask)) begin
        failures++;
        $display("FAIL %s: cycle %0d actual=%b expected=%b mask=%b",
                 e.tag, cyc, obs & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  task automatic push(input int due, input logic [8:0] m, input logic [8:0] v,
                      input string tag);
    exp_t e;
    e.due = due; e.mask = m; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;
    push(c0 + 1, M_ALL, 9'h000, "R11 reset state");
    wait_to(c0 + 2);
    blk_wdata = 4'b1011; blk_wr = 1'b1;
    push(c0 + 3, M_EN, 9'h00B, "R6 write in normal mode");
    @(negedge clk); blk_wr = 1'b0;
    drain();

    // R2 R3 R4: settling window, restart by strobe, disabled entry
    c0 = cyc;
    err_dis = 1'b1; ldo_en = 1'b1;
    push(c0 + 1, M_LDO, M_LDO, "R5 regulator enable passes in normal");
    push(c0 + BL + 1, M_ERR, 9'h000, "R3 strobe delays error");
    push(c0 + 11 + BL, M_ERR, 9'h000, "R2 no error inside window");
    push(c0 + 12 + BL, M_ERR | M_FLT, M_ERR, "R2 error after window, R4 no fault when disabled");
    wait_to(c0 + 10);
    vsel_stb = 1'b1; @(negedge clk); vsel_stb = 1'b0;
    drain();

    // R1 rise, R9 read clears
    c0 = cyc;
    pg_raw = 1'b1;
    push(c0 + 1, M_PG, M_PG, "R1 rise after one cycle");
    push(c0 + 3, M_ERR, 9'h000, "R9 read clears error");
    wait_to(c0 + 2);
    pulse_rd();
    drain();

    // R1 short low pulse rejected
    c0 = cyc;
    pg_raw = 1'b0;
    push(c0 + DG - 1, M_PG, M_PG, "R1 short pulse pending");
    push(c0 + DG + 1, M_PG | M_ERR, M_PG, "R1 short pulse rejected");
    wait_to(c0 + DG - 1);
    pg_raw = 1'b1;
    drain();

    // R1 fall, R4 entry, R5 mask, R6 ignore, R9 set wins, R7 recheck exit
    c0 = cyc;
    err_dis = 1'b0; pg_raw = 1'b0;
    e = c0 + DG + 1;
    push(c0 + DG, M_PG | M_ERR | M_FLT, 9'h000, "R1 fall after full low run");
    push(e, M_ALL, 9'h0F0, "R4 entry, R5 masked enables");
    push(e + 2, M_EN, 9'h000, "R6 write ignored in fault");
    push(e + 3, M_ERR | M_FLT, M_ERR | M_FLT, "R8 no exit with pg low, R9 set beats read");
    push(e + RC - 1, M_FLT, M_FLT, "R7 still in fault before recheck");
    push(e + RC, M_ALL, 9'h19B, "R7 recheck exit restores, R9 error kept");
    wait_to(e);
    blk_wdata = 4'b0110; blk_wr = 1'b1;
    @(negedge clk); blk_wr = 1'b0;
    wait_to(e + 2);
    pulse_rd();
    wait_to(e + 5);
    pg_raw = 1'b1;
    drain();

    // R8 read exit
    c0 = cyc;
    pg_raw = 1'b0;
    e = c0 + DG + 1;
    push(e, M_FLT | M_EN, M_FLT, "R5 re-entry masks enables");
    push(e + 3, M_FLT, M_FLT, "R8 no exit before read");
    push(e + 4, M_FLT | M_ERR | M_EN, 9'h00B, "R8 read exit restores, R9 read clears");
    wait_to(e);
    pg_raw = 1'b1;
    wait_to(e + 3);
    pulse_rd();
    drain();

    // R10 nested over-temperature
    c0 = cyc;
    pg_raw = 1'b0;
    e = c0 + DG + 1;
    push(e + 1, M_FLT | M_OTM | M_LDO | M_EN, M_FLT | M_OTM, "R10 ot state turns regulator off");
    push(e + 5, M_FLT | M_LDO | M_EN, M_FLT | M_LDO, "R10 return to regulator fault");
    push(e + 8, M_FLT | M_LDO | M_EN, M_LDO | 9'h00B, "R10 restore after nesting");
    wait_to(e);
    ot_flag = 1'b1;
    wait_to(e + 4);
    ot_flag = 1'b0;
    wait_to(e + 5);
    pg_raw = 1'b1;
    wait_to(e + 7);
    pulse_rd();
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule